// File: doc/BRIEF.md
# Tagged Operand Narrowing Unit

This unit halves the element width of tagged operands. Every operand is a block of `VB` bytes with a width code (element size in bytes is 2 to the code) and a two-bit marker per byte that tells ordinary data from "none" and "invalid-result" elements. The same operation serves two forms. In scalar form it takes one operand and narrows its single element. In vector form it takes two operands of N elements each and packs them into one operand of 2N elements of half the size, so the element count is preserved.

A policy field in the operation picks what happens when a value does not fit in the narrow width: keep the low bits, mark the element invalid, or clamp it to the narrow limits. A signedness bit selects signed or unsigned range checks. Markers travel with the data. An impossible request (narrowing a one-byte operand, mixing widths, a reserved policy) faults at once. The unit has a fixed two-stage pipeline.

Top module: `narrow_unit`

## Requirements
- R1: A request accepted with `in_valid` high appears on the outputs with `out_valid` high exactly two clock edges later; with `in_valid` low, `out_valid` is low two edges later.
- R2: In vector form (`in_vec`=1), source element i of A goes to result element i and source element i of B goes to result element N+i, where N = VB / element bytes; element k occupies result bytes starting at k times the narrow element size (little-endian, lane 0 at the lowest byte).
- R3: In scalar form (`in_vec`=0), only element 0 of A is narrowed into the lowest bytes; all other result bytes and markers are zero, and the B inputs have no effect.
- R4: Policy code 0 (wrap) keeps the low half of each ordinary element and leaves its marker at 00, whether it fits or not.
- R5: Policy code 1 (mark) keeps the low half and sets every byte marker of an overflowing ordinary element to 10 (invalid), without raising a fault.
- R6: Policy code 2 (clamp) replaces an overflowing ordinary element by the narrow limit: all ones when unsigned; 0111..1 for a non-negative and 1000..0 for a negative source when signed. Markers stay 00.
- R7: Overflow is unsigned (any set bit in the upper half) when `in_sgn`=0 and signed (value outside the narrow two's-complement range) when `in_sgn`=1.
- R8: An element whose lowest-byte marker is nonzero (01 none, 10 or 11 invalid) keeps that marker code on all its result bytes, its data is the low half, and no overflow rule applies.
- R9: A non-faulting result carries width code `a_wc` minus one.
- R10: A width error (`a_wc`=0, element wider than the operand, vector form with `b_wc`≠`a_wc`, or policy code 3) sets `out_fault` with data, markers and width code all zero.
- R11: While `rst_n` is low, `out_valid`, `out_fault`, `out_data`, `out_mark` and `out_wc` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_vec | input | 1 | 1 = vector form (two sources), 0 = scalar form |
| in_pol | input | 2 | Overflow policy: 0 wrap, 1 mark, 2 clamp, 3 reserved |
| in_sgn | input | 1 | 1 = signed range checks and limits |
| a_data | input | VB*8 | First source data |
| a_wc | input | 2 | First source width code |
| a_mark | input | VB*2 | First source per-byte markers |
| b_data | input | VB*8 | Second source data |
| b_wc | input | 2 | Second source width code |
| b_mark | input | VB*2 | Second source per-byte markers |
| out_valid | output | 1 | Result present |
| out_fault | output | 1 | Width error |
| out_data | output | VB*8 | Narrowed data |
| out_wc | output | 2 | Result width code |
| out_mark | output | VB*2 | Result per-byte markers |

## Verification
A wrong lane offset or a swapped source half shows as misplaced bytes in the very result that follows the faulty request, two edges later, so every packed vector exposes it at once. A wrong overflow decision shows in the same result as a wrong marker (mark policy) or a wrong limit value (clamp policy), and only for values near the narrow range edges, which is why the stimulus aims at those edges in both signedness modes. A stale pipeline register would show as a result shifted by one request or as `out_valid` out of step with the requests.

// File: rtl/nu_pkg.sv
package nu_pkg;

  typedef enum logic [1:0] {
    POL_WRAP = 2'd0,
    POL_MARK = 2'd1,
    POL_CLAMP = 2'd2,
    POL_RSVD = 2'd3
  } pol_e;

  localparam logic [1:0] MK_ORD = 2'b00;
  localparam logic [1:0] MK_INV = 2'b10;

  // Request is impossible to carry out: no narrower width, mixed widths,
  // element wider than the operand, or a reserved policy code.
  function automatic logic width_bad(input logic vec, input logic [1:0] pol,
                                     input logic [1:0] awc, input logic [1:0] bwc,
                                     input int maxc);
    logic bad;
    bad = (awc == 2'd0) || (int'(awc) > maxc) || (pol == 2'd3);
    if (vec && (bwc != awc)) bad = 1'b1;
    return bad;
  endfunction

endpackage

// File: rtl/nu_lane.sv
module nu_lane
  import nu_pkg::*;
#(
  parameter int SB = 4
) (
  input  logic [SB*8-1:0] src,
  input  logic [1:0]      kind,
  input  pol_e            pol,
  input  logic            sgn,
  output logic [SB*4-1:0] res,
  output logic [1:0]      rmark,
  output logic            ovf
);
  localparam int HB = SB * 4;

  function automatic logic over_u(input logic [SB*8-1:0] v);
    return |v[SB*8-1:HB];
  endfunction

  function automatic logic over_s(input logic [SB*8-1:0] v);
    logic [HB:0] top;
    top = v[SB*8-1:HB-1];
    return !((&top) || (~|top));
  endfunction

  function automatic logic [HB-1:0] limit(input logic neg, input logic s);
    if (!s) return '1;
    return neg ? {1'b1, {(HB-1){1'b0}}} : {1'b0, {(HB-1){1'b1}}};
  endfunction

  logic ordinary;
  assign ordinary = (kind == MK_ORD);
  assign ovf = ordinary && (sgn ? over_s(src) : over_u(src));

  always_comb begin
    res   = src[HB-1:0];
    rmark = kind;
    if (ordinary && ovf) begin
      if (pol == POL_CLAMP) res = limit(src[SB*8-1], sgn);
      if (pol == POL_MARK) rmark = MK_INV;
    end
  end

endmodule

// File: rtl/nu_path.sv
module nu_path
  import nu_pkg::*;
#(
  parameter int VB = 16,
  parameter int C  = 2
) (
  input  logic [VB*8-1:0] a_data,
  input  logic [VB*2-1:0] a_mark,
  input  logic [VB*8-1:0] b_data,
  input  logic [VB*2-1:0] b_mark,
  input  logic            vec,
  input  pol_e            pol,
  input  logic            sgn,
  output logic [VB*8-1:0] d,
  output logic [VB*2-1:0] m,
  output logic [VB-1:0]   ovf
);
  localparam int SB = 1 << C;
  localparam int OB = SB / 2;
  localparam int NL = VB / SB;

  if (2 * NL < VB) begin : g_pad
    assign ovf[VB-1:2*NL] = '0;
  end

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [OB*8-1:0] ra, rb;
    logic [1:0]      ma, mb;
    logic            oa, ob;
    logic            keep_a;

    nu_lane #(.SB(SB)) u_a (
      .src(a_data[i*SB*8 +: SB*8]), .kind(a_mark[i*SB*2 +: 2]),
      .pol(pol), .sgn(sgn), .res(ra), .rmark(ma), .ovf(oa)
    );
    nu_lane #(.SB(SB)) u_b (
      .src(b_data[i*SB*8 +: SB*8]), .kind(b_mark[i*SB*2 +: 2]),
      .pol(pol), .sgn(sgn), .res(rb), .rmark(mb), .ovf(ob)
    );

    assign keep_a = vec || (i == 0);

    assign d[i*OB*8 +: OB*8]      = keep_a ? ra : '0;
    assign m[i*OB*2 +: OB*2]      = keep_a ? {OB{ma}} : '0;
    assign d[(NL+i)*OB*8 +: OB*8] = vec ? rb : '0;
    assign m[(NL+i)*OB*2 +: OB*2] = vec ? {OB{mb}} : '0;
    assign ovf[i]                 = keep_a && oa;
    assign ovf[NL+i]              = vec && ob;
  end

endmodule

// File: rtl/narrow_unit.sv
module narrow_unit
  import nu_pkg::*;
#(
  parameter int VB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_vec,
  input  logic [1:0]        in_pol,
  input  logic              in_sgn,
  input  logic [VB*8-1:0]   a_data,
  input  logic [1:0]        a_wc,
  input  logic [VB*2-1:0]   a_mark,
  input  logic [VB*8-1:0]   b_data,
  input  logic [1:0]        b_wc,
  input  logic [VB*2-1:0]   b_mark,
  output logic              out_valid,
  output logic              out_fault,
  output logic [VB*8-1:0]   out_data,
  output logic [1:0]        out_wc,
  output logic [VB*2-1:0]   out_mark
);
  localparam int DW   = VB * 8;
  localparam int MW   = VB * 2;
  localparam int LG   = $clog2(VB);
  localparam int MAXC = (LG < 3) ? LG : 3;

  // stage 1: captured request
  logic          s1_valid, s1_vec, s1_sgn;
  logic [1:0]    s1_pol, s1_awc, s1_bwc;
  logic [DW-1:0] s1_adata, s1_bdata;
  logic [MW-1:0] s1_amark, s1_bmark;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_vec   <= 1'b0;
      s1_sgn   <= 1'b0;
      s1_pol   <= '0;
      s1_awc   <= '0;
      s1_bwc   <= '0;
      s1_adata <= '0;
      s1_bdata <= '0;
      s1_amark <= '0;
      s1_bmark <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_vec   <= in_vec;
      s1_sgn   <= in_sgn;
      s1_pol   <= in_pol;
      s1_awc   <= a_wc;
      s1_bwc   <= b_wc;
      s1_adata <= a_data;
      s1_bdata <= b_data;
      s1_amark <= a_mark;
      s1_bmark <= b_mark;
    end
  end

  // named internal events for the checker
  logic s1_fault;
  logic s1_any_ovf;
  assign s1_fault = width_bad(s1_vec, s1_pol, s1_awc, s1_bwc, MAXC);

  logic [DW-1:0] path_d [4];
  logic [MW-1:0] path_m [4];
  logic [VB-1:0] path_o [4];

  for (genvar c = 0; c < 4; c++) begin : g_width
    if (c >= 1 && c <= MAXC) begin : g_on
      nu_path #(.VB(VB), .C(c)) u_path (
        .a_data(s1_adata), .a_mark(s1_amark),
        .b_data(s1_bdata), .b_mark(s1_bmark),
        .vec(s1_vec), .pol(pol_e'(s1_pol)), .sgn(s1_sgn),
        .d(path_d[c]), .m(path_m[c]), .ovf(path_o[c])
      );
    end else begin : g_off
      assign path_d[c] = '0;
      assign path_m[c] = '0;
      assign path_o[c] = '0;
    end
  end

  logic [DW-1:0] nd;
  logic [MW-1:0] nm;
  always_comb begin
    nd = path_d[s1_awc];
    nm = path_m[s1_awc];
  end
  assign s1_any_ovf = (|path_o[s1_awc]) && !s1_fault;

  // stage 2: result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_data  <= '0;
      out_mark  <= '0;
      out_wc    <= '0;
    end else begin
      out_valid <= s1_valid;
      out_fault <= s1_valid && s1_fault;
      out_data  <= (s1_valid && !s1_fault) ? nd : '0;
      out_mark  <= (s1_valid && !s1_fault) ? nm : '0;
      out_wc    <= (s1_valid && !s1_fault) ? 2'(s1_awc - 2'd1) : '0;
    end
  end

endmodule

// File: rtl/narrow_unit_chk.sv
module narrow_unit_chk #(
  parameter int VB = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      a_wc,
  input logic            out_valid,
  input logic            out_fault,
  input logic [VB*8-1:0] out_data,
  input logic [1:0]      out_wc,
  input logic [VB*2-1:0] out_mark,
  input logic            s1_valid,
  input logic            s1_fault,
  input logic [1:0]      s1_pol,
  input logic [VB*2-1:0] s1_amark,
  input logic [VB*2-1:0] s1_bmark,
  input logic            s1_any_ovf
);

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  p_fault_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> (out_valid && out_data == '0 && out_mark == '0 && out_wc == 2'd0));

  p_byte_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_wc == 2'd0) |=> ##1 (out_valid && out_fault));

  p_width_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_fault) |=> (out_wc == 2'($past(a_wc, 2) - 2'd1)));

  p_mark_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_pol == 2'd1 && s1_any_ovf) |=> (out_mark != '0 && !out_fault));

  p_clamp_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_fault && s1_pol == 2'd2 && s1_amark == '0 && s1_bmark == '0)
      |=> (out_mark == '0));

  p_wrap_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_fault && s1_pol == 2'd0 && s1_amark == '0 && s1_bmark == '0)
      |=> (out_mark == '0));

endmodule

bind narrow_unit narrow_unit_chk #(.VB(VB)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_wc(a_wc),
  .out_valid(out_valid), .out_fault(out_fault), .out_data(out_data),
  .out_wc(out_wc), .out_mark(out_mark),
  .s1_valid(s1_valid), .s1_fault(s1_fault), .s1_pol(s1_pol),
  .s1_amark(s1_amark), .s1_bmark(s1_bmark), .s1_any_ovf(s1_any_ovf)
);

// File: tb/tb_narrow_unit.sv
module tb_narrow_unit;
  localparam int CLK_PERIOD = 10;
  localparam int VB = 16;
  localparam int HMAX = 4096;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0, in_vec = 1'b0, in_sgn = 1'b0;
  logic [1:0]      in_pol = '0, a_wc = '0, b_wc = '0;
  logic [VB*8-1:0] a_data = '0, b_data = '0;
  logic [VB*2-1:0] a_mark = '0, b_mark = '0;
  logic            out_valid, out_fault;
  logic [VB*8-1:0] out_data;
  logic [1:0]      out_wc;
  logic [VB*2-1:0] out_mark;

  always #(CLK_PERIOD/2) clk = ~clk;

  narrow_unit #(.VB(VB)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
    .in_pol(in_pol), .in_sgn(in_sgn), .a_data(a_data), .a_wc(a_wc),
    .a_mark(a_mark), .b_data(b_data), .b_wc(b_wc), .b_mark(b_mark),
    .out_valid(out_valid), .out_fault(out_fault), .out_data(out_data),
    .out_wc(out_wc), .out_mark(out_mark)
  );

  int checks = 0, failures = 0, idx = 0;
  bit finished = 1'b0;

  logic            h_v [HMAX];
  logic            h_f [HMAX];
  logic [VB*8-1:0] h_d [HMAX];
  logic [VB*2-1:0] h_m [HMAX];
  logic [1:0]      h_wc[HMAX];
  string           h_tag[HMAX];

  // behavioural reference, range checks done on integers
  task automatic ref_model(input logic vec, input logic [1:0] pol, input logic sgn,
                           input logic [127:0] ad, input logic [1:0] awc, input logic [31:0] am,
                           input logic [127:0] bd, input logic [1:0] bwc, input logic [31:0] bm,
                           output logic [127:0] d, output logic [31:0] m,
                           output logic [1:0] wc, output logic f);
    d = '0; m = '0; wc = '0;
    f = (awc == 0) || (pol == 3) || (vec && bwc != awc);
    if (f) return;
    wc = awc - 1;
    begin
      int sb = 1 << awc;
      int ob = sb / 2;
      int n = VB / sb;
      int hb = ob * 8;
      int lanes = vec ? 2 * n : 1;
      logic [63:0] mask = (64'd1 << hb) - 1;
      longint smax = (longint'(1) <<< (hb - 1)) - 1;
      longint smin = -smax - 1;
      for (int k = 0; k < lanes; k++) begin
        logic [127:0] sd;
        logic [31:0] sm;
        logic [63:0] uv, r;
        longint sv;
        logic [1:0] kind, mk;
        logic over;
        int i;
        i = (k < n) ? k : k - n;
        sd = (k < n) ? ad : bd;
        sm = (k < n) ? am : bm;
        uv = '0;
        for (int j = 0; j < sb; j++) uv[j*8 +: 8] = sd[(i*sb + j)*8 +: 8];
        kind = sm[(i*sb)*2 +: 2];
        sv = $signed(uv << (64 - sb*8)) >>> (64 - sb*8);
        over = sgn ? (sv > smax || sv < smin) : ((uv >> hb) != 0);
        r = uv & mask;
        mk = kind;
        if (kind == 2'b00 && over) begin
          if (pol == 1) mk = 2'b10;
          if (pol == 2) r = sgn ? ((sv < 0) ? (64'(smin) & mask) : 64'(smax)) : mask;
        end
        for (int j = 0; j < ob; j++) begin
          d[(k*ob + j)*8 +: 8] = r[j*8 +: 8];
          m[(k*ob + j)*2 +: 2] = mk;
        end
      end
    end
  endtask

  task automatic check1(input string tag, input string what, input logic [127:0] act,
                        input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_out();
    if (idx < 2) begin
      check1("R1", "out_valid", 128'(out_valid), 128'(0));
      return;
    end
    begin
      int p = idx - 2;
      check1("R1", "out_valid", 128'(out_valid), 128'(h_v[p]));
      if (h_v[p]) begin
        check1(h_f[p] ? "R10" : h_tag[p], "out_fault", 128'(out_fault), 128'(h_f[p]));
        check1(h_f[p] ? "R10" : h_tag[p], "out_data", out_data, h_d[p]);
        check1(h_f[p] ? "R10" : h_tag[p], "out_mark", 128'(out_mark), 128'(h_m[p]));
        check1(h_f[p] ? "R10" : "R9", "out_wc", 128'(out_wc), 128'(h_wc[p]));
      end
    end
  endtask

  task automatic step(input string tag, input logic v, input logic vec,
                      input logic [1:0] pol, input logic sgn,
                      input logic [127:0] ad, input logic [1:0] awc, input logic [31:0] am,
                      input logic [127:0] bd, input logic [1:0] bwc, input logic [31:0] bm);
    @(negedge clk);
    compare_out();
    in_valid = v; in_vec = vec; in_pol = pol; in_sgn = sgn;
    a_data = ad; a_wc = awc; a_mark = am;
    b_data = bd; b_wc = bwc; b_mark = bm;
    h_v[idx] = v;
    h_tag[idx] = tag;
    ref_model(vec, pol, sgn, ad, awc, am, bd, bwc, bm, h_d[idx], h_m[idx], h_wc[idx], h_f[idx]);
    idx++;
  endtask

  task automatic idle();
    step("R1", 1'b0, 1'b0, 2'd0, 1'b0, '0, 2'd0, '0, '0, 2'd0, '0);
  endtask

  function automatic logic [31:0] gen_marks(input logic [1:0] wc);
    logic [31:0] mk = '0;
    int sb = 1 << wc;
    for (int e = 0; e < VB / sb; e++) begin
      logic [1:0] k;
      int r = int'($urandom % 8);
      k = (r == 0) ? 2'b01 : (r == 1) ? 2'b10 : (r == 2) ? 2'b11 : 2'b00;
      for (int j = 0; j < sb; j++) mk[(e*sb + j)*2 +: 2] = k;
    end
    return mk;
  endfunction

  localparam logic [127:0] A32 = 128'h8000_0000_FFFF_8000_0001_0000_0000_7FFF;
  localparam logic [127:0] B32 = 128'h0000_FFFF_FFFF_7FFF_7FFF_FFFF_0000_0001;
  localparam logic [127:0] A64 = 128'hFFFF_FFFF_8000_0000_0000_0001_0000_0000;
  localparam logic [127:0] B16 = 128'h7F80_FF80_0080_00FF_8000_017F_FFFF_0042;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: outputs held at zero in reset
    check1("R11", "reset out_valid", 128'(out_valid), 128'(0));
    check1("R11", "reset out_fault", 128'(out_fault), 128'(0));
    check1("R11", "reset out_data", out_data, '0);
    check1("R11", "reset out_mark", 128'(out_mark), 128'(0));
    check1("R11", "reset out_wc", 128'(out_wc), 128'(0));
    rst_n = 1'b1;

    // R2/R4: packing order under wrap, each width
    step("R2", 1, 1, 2'd0, 0, A32, 2'd2, '0, B32, 2'd2, '0);
    step("R2", 1, 1, 2'd0, 0, A64, 2'd3, '0, B32, 2'd3, '0);
    step("R4", 1, 1, 2'd0, 1, B16, 2'd1, '0, A32, 2'd1, '0);
    idle();
    // R5/R7: mark policy, unsigned then signed
    step("R5", 1, 1, 2'd1, 0, A32, 2'd2, '0, B32, 2'd2, '0);
    step("R5", 1, 1, 2'd1, 1, A32, 2'd2, '0, B32, 2'd2, '0);
    step("R7", 1, 1, 2'd1, 1, B16, 2'd1, '0, B16, 2'd1, '0);
    // R6: clamp policy both signedness modes
    step("R6", 1, 1, 2'd2, 0, A32, 2'd2, '0, B32, 2'd2, '0);
    step("R6", 1, 1, 2'd2, 1, A32, 2'd2, '0, B32, 2'd2, '0);
    step("R6", 1, 1, 2'd2, 1, A64, 2'd3, '0, B16, 2'd3, '0);
    step("R6", 1, 1, 2'd2, 1, B16, 2'd1, '0, A64, 2'd1, '0);
    // R8: none/invalid markers pass through untouched by policy
    step("R8", 1, 1, 2'd2, 1, A32, 2'd2, 32'h0000_AA55, B32, 2'd2, 32'hFF00_5500);
    step("R8", 1, 1, 2'd1, 0, A32, 2'd2, 32'h5555_0000, B32, 2'd2, 32'h0000_FFFF);
    // R3: scalar form, B holds garbage that must not matter
    step("R3", 1, 0, 2'd0, 0, A32, 2'd2, '0, B16, 2'd1, 32'hFFFF_FFFF);
    step("R3", 1, 0, 2'd2, 1, A64, 2'd3, '0, B32, 2'd0, 32'h5555_5555);
    step("R3", 1, 0, 2'd1, 0, B16, 2'd1, 32'h0000_0005, A32, 2'd3, '0);
    // R10: width errors
    step("R10", 1, 1, 2'd0, 0, A32, 2'd0, '0, B32, 2'd0, '0);
    step("R10", 1, 0, 2'd2, 0, A32, 2'd0, '0, B32, 2'd2, '0);
    step("R10", 1, 1, 2'd0, 0, A32, 2'd2, '0, B32, 2'd3, '0);
    step("R10", 1, 1, 2'd3, 0, A32, 2'd2, '0, B32, 2'd2, '0);
    idle();
    idle();
    // mixed stream with bubbles
    for (int t = 0; t < 300; t++) begin
      logic [1:0] wc = 2'(1 + ($urandom % 3));
      logic vec = 1'($urandom);
      logic [1:0] pol = 2'($urandom % 3);
      logic [1:0] bw = ($urandom % 16 == 0) ? 2'($urandom) : wc;
      logic [127:0] ad = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] bd = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom % 3 == 0) ad = ad & 128'h00FF_00FF_0000_FFFF_0000_00FF_0000_0FFF;
      step(vec ? "R2" : "R3", 1'($urandom % 5 != 0), vec, pol, 1'($urandom),
           ad, wc, gen_marks(wc), bd, bw, gen_marks(bw));
    end
    idle();
    idle();
    idle();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule